// File: doc/BRIEF.md
# Serial Command Port for an Eight-Channel Switch Configuration Bank

This block is the command side of an eight-channel switch controller. A host talks to it over a four-wire serial link. Each transfer is one or more 16-bit words sent most significant bit first. An active-low select line frames the transfer. A frame carries a two-bit opcode, a three-bit register address and an eight-bit value. The block keeps six configuration registers and one read-only status slot. The rest of the chip uses the configuration registers directly through dedicated output ports.

The serial clock and select are not used as clocks. They are brought into the system clock through a synchronizer, and their edges are detected in that domain. When select falls, a 16-bit word is loaded into the shift register and then shifted out. Normally this word is the diagnosis word supplied from outside. In the frame after a read command, it is a tagged echo holding the requested register. The shift register passes data straight through, so several devices can share one select line in a daisy chain.

A frame is accepted only when a non-zero multiple of eight serial clocks has been counted. An accepted frame raises a one-cycle pulse that tells the diagnosis logic to clear its latched flags. A frame with any other clock count is discarded.

Top module: `spi_cfg_frontend`

## Requirements
- R1: The output enable `miso_oe_o` is 1 while the select line is low and 0 while it is high.
- R2: On the falling edge of select, the shift register loads a word. Bits leave on `miso_o` MSB first, and each new bit appears after a rising serial clock edge. `mosi_i` is captured on each falling serial clock edge.
- R3: A frame whose serial clock count is zero or not a multiple of eight changes no register and gives no `accept_o` pulse.
- R4: The command is taken from the last 16 bits shifted in. Opcode is bits 15:14, address is bits 10:8 and value is bits 7:0. Bits 13:11 are ignored.
- R5: Opcode 11 writes the value to the addressed register. Address map: 1 input map, 2 combine mode, 3 overload mode, 4 overheat mode, 5 slope, 7 drive. The write pulses `wr_stb_o` bit n for address n, in the same cycle as `accept_o`.
- R6: A write to address 0 or to address 6 (status) changes no register and pulses no strobe bit.
- R7: Every accepted frame gives exactly one single-cycle `accept_o` pulse, whatever its opcode.
- R8: Opcode 00 changes no register.
- R9: After an accepted opcode 01 frame, the next frame loads the word {01000, address, content} in place of the diagnosis word. Content is 00h for address 0 and `status_i` for address 6. Frames after that load `diag_i` again.
- R10: Opcode 10 restores every register to its default: 08h for the input map, 00h for all others.
- R11: `rst_n` low restores every register to its default and cancels a pending read echo.
- R12: When more than 16 clocks are sent under one select, each bit on `miso_o` is the bit received 16 clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (pin or power-on) |
| sel_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Drive enable for the serial data out pad |
| diag_i | input | 16 | Diagnosis word loaded when select falls |
| status_i | input | CH | Content of the read-only status slot |
| accept_o | output | 1 | One-cycle pulse per accepted frame; clears diagnosis flags |
| wr_stb_o | output | 8 | One-hot write strobe, bit n for address n |
| wr_data_o | output | CH | Value of the last write |
| map_o | output | CH | Input map register |
| bool_o | output | CH | Combine mode register |
| ovl_o | output | CH | Overload mode register |
| ovt_o | output | CH | Overheat mode register |
| slew_o | output | CH | Slope register |
| drive_o | output | CH | Drive register |

## Verification
The bench builds the block with CH = 8, two synchronizer stages, eight-clock framing and an input map default of 08h. With eight channels the whole value byte is exercised. With two stages, edge detection lags the serial lines by about three system clocks, so a six-cycle half period for the serial clock leaves slack for sampling. Eight-clock framing puts frames of 8, 16, 24 and 32 clocks on the accepted side, and 0, 5 and 12 clocks on the discarded side. A 32-clock frame also shows the daisy-chain pass-through and a command taken from the last word.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

   localparam int FRAME_W = 16;
   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 8;
   localparam int NREG    = 1 << ADDR_W;

   typedef enum logic [1:0] {
      OP_DIAG  = 2'b00,
      OP_READ  = 2'b01,
      OP_CLEAR = 2'b10,
      OP_WRITE = 2'b11
   } op_e;

   typedef struct packed {
      op_e               op;
      logic [2:0]        rsv;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } frame_t;

   localparam logic [ADDR_W-1:0] A_NONE  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MAP   = 3'd1;
   localparam logic [ADDR_W-1:0] A_BOOL  = 3'd2;
   localparam logic [ADDR_W-1:0] A_OVL   = 3'd3;
   localparam logic [ADDR_W-1:0] A_OVT   = 3'd4;
   localparam logic [ADDR_W-1:0] A_SLEW  = 3'd5;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;
   localparam logic [ADDR_W-1:0] A_DRIVE = 3'd7;

   localparam logic [4:0] ECHO_TAG = 5'b01000;

   function automatic logic is_writable(input logic [ADDR_W-1:0] a);
      return (a != A_NONE) && (a != A_STAT);
   endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cfg_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
   parameter int FRAME_W   = 16,
   parameter int BYTE_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_fall,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               si,
   input  logic [FRAME_W-1:0] load_word,
   output logic               so,
   output logic [FRAME_W-1:0] word,
   output logic               frame_ok
);

   localparam int CNT_W = $clog2(BYTE_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

   if (BYTE_BITS < 2 || (1 << CNT_W) != BYTE_BITS) begin : g_bad_byte
      $error("spi_cfg_shifter needs a power-of-two framing modulus");
   end

   logic [FRAME_W-1:0] sr_q;
   logic               so_q;
   logic [CNT_W-1:0]   mod_q;
   logic               seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         so_q   <= 1'b0;
         mod_q  <= '0;
         seen_q <= 1'b0;
      end else if (cs_fall) begin
         sr_q   <= load_word;
         so_q   <= load_word[FRAME_W-1];
         mod_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (sclk_rise) so_q <= sr_q[FRAME_W-1];
         if (sclk_fall) begin
            sr_q <= {sr_q[FRAME_W-2:0], si};
            if (mod_q == CNT_LAST) begin
               mod_q  <= '0;
               seen_q <= 1'b1;
            end else begin
               mod_q <= mod_q + 1'b1;
            end
         end
      end
   end

   assign so       = so_q;
   assign word     = sr_q;
   assign frame_ok = seen_q && (mod_q == '0);

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
   import spi_cfg_pkg::*;
#(
   parameter int          CH          = 8,
   parameter logic [7:0]  MAP_DEFAULT = 8'h08
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREG-1:0]          wr_stb,
   input  logic [CH-1:0]            wr_data,
   input  logic                     clear,
   input  logic [CH-1:0]            status,
   output logic [NREG-1:0][CH-1:0]  bank
);

   for (genvar a = 0; a < NREG; a++) begin : g_slot
      if (a == int'(A_NONE)) begin : g_none
         assign bank[a] = '0;
      end else if (a == int'(A_STAT)) begin : g_stat
         assign bank[a] = status;
      end else begin : g_rw
         localparam logic [CH-1:0] DEF =
            (a == int'(A_MAP)) ? MAP_DEFAULT[CH-1:0] : '0;
         logic [CH-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= DEF;
            else if (clear)     q <= DEF;
            else if (wr_stb[a]) q <= wr_data;
         end
         assign bank[a] = q;
      end
   end

endmodule

// File: rtl/spi_cfg_frontend.sv
module spi_cfg_frontend
   import spi_cfg_pkg::*;
#(
   parameter int         CH          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         BYTE_BITS   = 8,
   parameter logic [7:0] MAP_DEFAULT = 8'h08
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_n_i,
   input  logic                sclk_i,
   input  logic                mosi_i,
   output logic                miso_o,
   output logic                miso_oe_o,
   input  logic [FRAME_W-1:0]  diag_i,
   input  logic [CH-1:0]       status_i,
   output logic                accept_o,
   output logic [NREG-1:0]     wr_stb_o,
   output logic [CH-1:0]       wr_data_o,
   output logic [CH-1:0]       map_o,
   output logic [CH-1:0]       bool_o,
   output logic [CH-1:0]       ovl_o,
   output logic [CH-1:0]       ovt_o,
   output logic [CH-1:0]       slew_o,
   output logic [CH-1:0]       drive_o
);

   if (CH < 1 || CH > DATA_W) begin : g_bad_ch
      $error("spi_cfg_frontend: CH must lie in 1..8");
   end
   if (FRAME_W != 5 + ADDR_W + DATA_W) begin : g_bad_frame
      $error("spi_cfg_frontend: frame layout does not fill the word");
   end

   // ---------------- line synchronizer and edge detection ----------------
   logic [2:0] lines_s;
   logic       cs_s, sclk_s, si_s;
   logic       cs_d, sclk_d;
   logic       cs_fall, cs_rise, sclk_rise, sclk_fall;

   spi_cfg_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sel_n_i, sclk_i, mosi_i}),
      .q    (lines_s)
   );

   assign cs_s   = lines_s[2];
   assign sclk_s = lines_s[1];
   assign si_s   = lines_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   assign cs_fall   =  cs_d & ~cs_s;
   assign cs_rise   = ~cs_d &  cs_s;
   assign sclk_rise = ~sclk_d &  sclk_s & ~cs_s;
   assign sclk_fall =  sclk_d & ~sclk_s & ~cs_s;

   // ---------------- shift register ----------------
   logic [FRAME_W-1:0] echo_q;
   logic               pend_q;
   logic [FRAME_W-1:0] load_word;
   logic [FRAME_W-1:0] rx_word;
   logic               frame_ok;

   assign load_word = pend_q ? echo_q : diag_i;

   spi_cfg_shifter #(
      .FRAME_W  (FRAME_W),
      .BYTE_BITS(BYTE_BITS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_fall  (cs_fall),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .si       (si_s),
      .load_word(load_word),
      .so       (miso_o),
      .word     (rx_word),
      .frame_ok (frame_ok)
   );

   assign miso_oe_o = ~cs_s;

   // ---------------- command decode ----------------
   frame_t                  f;
   logic                    unused_rsv;
   logic [NREG-1:0][CH-1:0] bank;
   logic [DATA_W-1:0]       rd_byte;
   logic                    accept_q, clear_q;
   logic [NREG-1:0]         wr_stb_q;
   logic [CH-1:0]           wr_data_q;

   assign f          = frame_t'(rx_word);
   assign unused_rsv = ^f.rsv;
   assign rd_byte    = DATA_W'(bank[f.addr]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept_q  <= 1'b0;
         clear_q   <= 1'b0;
         wr_stb_q  <= '0;
         wr_data_q <= '0;
         pend_q    <= 1'b0;
         echo_q    <= '0;
      end else begin
         accept_q <= 1'b0;
         clear_q  <= 1'b0;
         wr_stb_q <= '0;
         if (cs_fall) pend_q <= 1'b0;
         if (cs_rise && frame_ok) begin
            accept_q <= 1'b1;
            unique case (f.op)
               OP_WRITE: begin
                  if (is_writable(f.addr)) begin
                     wr_stb_q  <= NREG'(1) << f.addr;
                     wr_data_q <= f.data[CH-1:0];
                  end
               end
               OP_READ: begin
                  pend_q <= 1'b1;
                  echo_q <= {ECHO_TAG, f.addr, rd_byte};
               end
               OP_CLEAR: clear_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   // ---------------- register bank ----------------
   spi_cfg_regbank #(
      .CH         (CH),
      .MAP_DEFAULT(MAP_DEFAULT)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb_q),
      .wr_data(wr_data_q),
      .clear  (clear_q),
      .status (status_i),
      .bank   (bank)
   );

   assign accept_o  = accept_q;
   assign wr_stb_o  = wr_stb_q;
   assign wr_data_o = wr_data_q;
   assign map_o     = bank[A_MAP];
   assign bool_o    = bank[A_BOOL];
   assign ovl_o     = bank[A_OVL];
   assign ovt_o     = bank[A_OVT];
   assign slew_o    = bank[A_SLEW];
   assign drive_o   = bank[A_DRIVE];

endmodule

module spi_cfg_frontend_chk #(
   parameter int CH = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          accept_o,
   input logic [7:0]    wr_stb_o,
   input logic [CH-1:0] map_o,
   input logic [CH-1:0] drive_o
);

   // R7
   accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !accept_o);

   // R5
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o));

   // R5
   stb_with_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb_o) |-> accept_o);

   // R6
   stb_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb_o[0] || wr_stb_o[6]));

   // R3
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_o != $past(drive_o)) |-> $past(accept_o));

   // R3
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map_o != $past(map_o)) |-> $past(accept_o));

endmodule

bind spi_cfg_frontend spi_cfg_frontend_chk #(.CH(CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .accept_o(accept_o),
   .wr_stb_o(wr_stb_o),
   .map_o   (map_o),
   .drive_o (drive_o)
);

// File: tb/spi_cfg_frontend_tb_top.sv
module spi_cfg_frontend_tb_top;

   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic        miso, miso_oe, accept;
   logic [15:0] diag_v = 16'h0000;
   logic [7:0]  status_v = 8'h00;
   logic [7:0]  wr_stb, wr_data;
   logic [7:0]  map_r, bool_r, ovl_r, ovt_r, slew_r, drive_r;

   always #4 clk = ~clk;

   spi_cfg_frontend #(
      .CH(8), .SYNC_STAGES(2), .BYTE_BITS(8), .MAP_DEFAULT(8'h08)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .mosi_i(mosi),
      .miso_o(miso), .miso_oe_o(miso_oe), .diag_i(diag_v), .status_i(status_v),
      .accept_o(accept), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
      .map_o(map_r), .bool_o(bool_r), .ovl_o(ovl_r), .ovt_o(ovt_r),
      .slew_o(slew_r), .drive_o(drive_r)
   );

   int checks = 0, fails = 0, acc_cnt = 0, exp_acc = 0;
   bit done = 1'b0;

   logic [7:0]  m_reg [8];
   logic        m_pend;
   logic [15:0] m_echo;

   always @(negedge clk) if (rst_n && accept) acc_cnt++;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic m_defaults();
      for (int a = 0; a < 8; a++) m_reg[a] = 8'h00;
      m_reg[1] = 8'h08;
      m_pend   = 1'b0;
   endtask

   function automatic logic [7:0] m_read(input logic [2:0] a);
      if (a == 3'd0) return 8'h00;
      if (a == 3'd6) return status_v;
      return m_reg[a];
   endfunction

   function automatic logic [15:0] mk(input logic [1:0] op, input logic [2:0] rsv,
                                      input logic [2:0] a, input logic [7:0] d);
      return {op, rsv, a, d};
   endfunction

   function automatic logic [47:0] regs_dut();
      return {drive_r, slew_r, ovt_r, ovl_r, bool_r, map_r};
   endfunction

   function automatic logic [47:0] regs_exp();
      return {m_reg[7], m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[1]};
   endfunction

   // Drives one select window with n clocks; returns the bits seen on miso.
   task automatic shift_frame(input logic [63:0] tx, input int n,
                              output logic [63:0] rx, output bit oe_mid);
      rx = '0;
      @(negedge clk) sel_n = 1'b0;
      repeat (HALF) @(negedge clk);
      oe_mid = miso_oe;
      for (int i = n - 1; i >= 0; i--) begin
         mosi = tx[i];
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         rx = {rx[62:0], miso};
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      sel_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   // Runs a frame against the reference model and checks outputs.
   task automatic run(input logic [63:0] tx, input int n);
      logic [15:0] loaded, sr;
      logic [63:0] exp_rx, rx;
      bit          oe_mid, was_echo, valid;
      string       tag;
      was_echo = m_pend;
      loaded   = m_pend ? m_echo : diag_v;
      m_pend   = 1'b0;
      sr       = loaded;
      exp_rx   = '0;
      for (int i = n - 1; i >= 0; i--) begin
         exp_rx = {exp_rx[62:0], sr[15]};
         sr     = {sr[14:0], tx[i]};
      end
      valid = (n > 0) && (n % 8 == 0);
      tag = "R3";
      if (valid) begin
         exp_acc++;
         case (sr[15:14])
            2'b11: begin
               tag = (sr[10:8] == 3'd0 || sr[10:8] == 3'd6) ? "R6" : "R5";
               if (sr[10:8] != 3'd0 && sr[10:8] != 3'd6) m_reg[sr[10:8]] = sr[7:0];
            end
            2'b01: begin
               tag    = "R9";
               m_pend = 1'b1;
               m_echo = {5'b01000, sr[10:8], m_read(sr[10:8])};
            end
            2'b10: begin
               tag = "R10";
               for (int a = 0; a < 8; a++) m_reg[a] = 8'h00;
               m_reg[1] = 8'h08;
            end
            default: tag = "R8";
         endcase
      end
      shift_frame(tx, n, rx, oe_mid);
      if (n > 0)
         check(rx == exp_rx, n > 16 ? "R12 pass-through" : (was_echo ? "R9 echo word" : "R2 loaded word"),
               rx, exp_rx);
      check(oe_mid && !miso_oe, "R1 output enable", {oe_mid, miso_oe}, 2'b10);
      check(acc_cnt == exp_acc, valid ? "R7 accept count" : "R3 accept count", acc_cnt, exp_acc);
      check(regs_dut() == regs_exp(), tag, regs_dut(), regs_exp());
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
   end

   initial begin
      int lens[9] = '{0, 5, 8, 12, 16, 16, 16, 24, 32};
      void'($urandom(32'h5eed_1234));
      m_defaults();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R11 reset state
      check(regs_dut() == regs_exp(), "R11 reset defaults", regs_dut(), regs_exp());
      check(!miso_oe && !accept && wr_stb == 8'h00, "R1 idle outputs", {miso_oe, accept, wr_stb}, 0);

      diag_v = 16'hC3A5; status_v = 8'h5A;
      run({48'h0, mk(2'b11, 3'b000, 3'd3, 8'hA5)}, 16);   // R5 write overload mode
      run({48'h0, mk(2'b11, 3'b101, 3'd7, 8'h3C)}, 16);   // R4 reserved bits ignored
      check(drive_r == 8'h3C, "R4 reserved bits ignored", drive_r, 8'h3C);
      run({48'h0, mk(2'b01, 3'b000, 3'd3, 8'h00)}, 16);   // R9 read
      run({48'h0, mk(2'b01, 3'b000, 3'd6, 8'h00)}, 16);   // R9 echo + read status
      run({48'h0, mk(2'b01, 3'b000, 3'd0, 8'h00)}, 16);   // R9 echo status, read addr 0
      run({48'h0, mk(2'b00, 3'b000, 3'd0, 8'hFF)}, 16);   // R9 echo of 00, R8 no change
      run({48'h0, mk(2'b00, 3'b000, 3'd1, 8'h00)}, 16);   // back to diag word
      run({48'h0, mk(2'b11, 3'b000, 3'd0, 8'hFF)}, 16);   // R6 addr 0
      run({48'h0, mk(2'b11, 3'b000, 3'd6, 8'hFF)}, 16);   // R6 status
      run({48'h0, mk(2'b11, 3'b000, 3'd1, 8'hFF)}, 12);   // R3 twelve clocks
      run({48'h0, mk(2'b11, 3'b000, 3'd1, 8'hFF)}, 0);    // R3 no clocks
      run({32'h0, mk(2'b11, 3'b000, 3'd2, 8'h77), mk(2'b11, 3'b000, 3'd5, 8'h99)}, 32); // R12
      run({48'h0, mk(2'b10, 3'b000, 3'd0, 8'h00)}, 16);   // R10 defaults
      run({48'h0, mk(2'b11, 3'b000, 3'd5, 8'h81)}, 8);    // R4 short frame, last 16 bits
      run({48'h0, mk(2'b01, 3'b000, 3'd1, 8'h00)}, 16);   // R9 pending read
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_defaults();
      repeat (4) @(negedge clk);
      check(regs_dut() == regs_exp(), "R11 reset pin mid-run", regs_dut(), regs_exp());
      run({48'h0, mk(2'b00, 3'b000, 3'd0, 8'h00)}, 16);   // R11 echo cancelled

      for (int k = 0; k < 220; k++) begin
         diag_v   = 16'($urandom());
         status_v = 8'($urandom());
         run({32'($urandom()), 32'($urandom())}, lens[$urandom_range(0, 8)]);
      end
      summary();
   end

endmodule